// File: doc/BRIEF.md
# Berger Code Self-Checking Checker

This block checks a separable Berger codeword. The codeword has an information field and a check field. The check field holds the number of zero bits in the information field, written as an unsigned binary number. A generator network inside the block counts the zeros in the received information bits and forms the bitwise inverse of that count. Each inverted bit is paired with the matching received check bit, so every pair is complementary when the two values agree.

A tree of two-rail cells reduces all the pairs to a single rail pair (f, g). For a valid codeword the pair is complementary (01 or 10). For any mismatch it is 00 or 11. Because the tree carries two rails all the way to the output, a stuck fault inside the tree also shows up as a non-complementary pair. A separate `error` output is high when f equals g, for logic downstream that only needs one flag.

A parameter sets the information width, and the check width is derived from it. A second parameter selects between a purely combinational path and a path with one output register stage.

Top module: `berger_tsc_checker`

## Requirements
- R1: The check port is ceil(log2(INFO_W+1)) bits wide. A codeword is valid exactly when the unsigned value on `chk` equals the number of 0 bits on `info`.
- R2: With INFO_W=8, info 8'b10101000 and chk 4'b0101 (five zeros) form a valid codeword: f and g differ and error is 0.
- R3: For every valid codeword, f and g are complementary (f != g).
- R4: For every input combination that is not a valid codeword, f equals g (00 or 11).
- R5: Every single-bit flip of a valid codeword, in either field, drives f equal to g.
- R6: Every unidirectional multi-bit error is flagged with f equal to g. This covers any set of bits forced to 1, or any set forced to 0, across both fields of a valid codeword.
- R7: `error` is 1 exactly when f equals g.
- R8: With REGISTERED=1, f, g and error show the verdict for the inputs present at the previous rising clock edge. They hold until the next edge.
- R9: With REGISTERED=1, while rst_n is low (active-low, asynchronous), f=0, g=1 and error=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset of the output register |
| info | input | INFO_W | Information field of the received codeword |
| chk | input | ceil(log2(INFO_W+1)) | Received check field (zero count) |
| f | output | 1 | First rail of the verdict pair |
| g | output | 1 | Second rail of the verdict pair |
| error | output | 1 | High when f equals g |

## Verification
The bench sweeps every info and check combination of the 8-bit configuration. This exposes a generator that counts ones instead of zeros, drops the carry of the top count bit, or mispairs rails in the tree. Any of those faults marks some valid codewords as bad or lets some bad words through. Single-bit flips and one-way bursts up to the full codeword length target a comparator that masks errors when several pairs fail at once. Such a comparator would show a complementary pair for a word with mixed corruption. The registered instance is sampled just before and just after each edge, so a missing or doubled stage shows up as a verdict one cycle early or late. Its reset value is checked against the 01 pair.

// File: rtl/berger_tsc_checker.sv
module berger_tsc_checker #(
  parameter int INFO_W     = 8,
  parameter bit REGISTERED = 1'b0,
  localparam int CHK_W     = $clog2(INFO_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [INFO_W-1:0] info,
  input  logic [CHK_W-1:0]  chk,
  output logic              f,
  output logic              g,
  output logic              error
);

  localparam int NODES = 2 * CHK_W - 1;

  logic [CHK_W-1:0] zero_cnt;
  logic [CHK_W-1:0] gen_n;
  logic             rail0 [NODES];
  logic             rail1 [NODES];

  always_comb begin
    zero_cnt = '0;
    for (int b = 0; b < INFO_W; b++)
      zero_cnt = zero_cnt + CHK_W'(~info[b]);
  end

  assign gen_n = ~zero_cnt;

  for (genvar j = 0; j < CHK_W; j++) begin : g_leaf
    assign rail0[CHK_W-1+j] = chk[j];
    assign rail1[CHK_W-1+j] = gen_n[j];
  end

  for (genvar n = 0; n < CHK_W - 1; n++) begin : g_cell
    assign rail0[n] = (rail0[2*n+1] & rail0[2*n+2]) | (rail1[2*n+1] & rail1[2*n+2]);
    assign rail1[n] = (rail0[2*n+1] & rail1[2*n+2]) | (rail1[2*n+1] & rail0[2*n+2]);
  end

  if (REGISTERED) begin : g_reg
    logic f_q, g_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        f_q <= 1'b0;
        g_q <= 1'b1;
      end else begin
        f_q <= rail0[0];
        g_q <= rail1[0];
      end
    end
    assign f = f_q;
    assign g = g_q;
  end else begin : g_comb
    logic unused_clk_rst;
    assign unused_clk_rst = clk ^ rst_n;
    assign f = rail0[0];
    assign g = rail1[0];
  end

  assign error = ~(f ^ g);

endmodule

// File: rtl/berger_tsc_props.sv
module berger_tsc_props #(
  parameter int INFO_W     = 8,
  parameter bit REGISTERED = 1'b0,
  localparam int CHK_W     = $clog2(INFO_W + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [INFO_W-1:0] info,
  input logic [CHK_W-1:0]  chk,
  input logic              f,
  input logic              g,
  input logic              error
);

  logic ref_ok;
  assign ref_ok = ($countones(~info) == int'(chk));

  if (REGISTERED) begin : g_reg
    a_r3_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
      ref_ok |=> (f != g));
    a_r4_invalid_next: assert property (@(posedge clk) disable iff (!rst_n)
      !ref_ok |=> (f == g));
    a_r8_error_follows: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (error == !$past(ref_ok)));
  end else begin : g_comb
    a_r3_valid_pair: assert property (@(posedge clk) disable iff (!rst_n)
      ref_ok |-> (f != g));
    a_r4_invalid_pair: assert property (@(posedge clk) disable iff (!rst_n)
      !ref_ok |-> (f == g));
    a_r7_error_flag: assert property (@(posedge clk) disable iff (!rst_n)
      error == !ref_ok);
  end

endmodule

bind berger_tsc_checker berger_tsc_props #(
  .INFO_W(INFO_W), .REGISTERED(REGISTERED)
) u_props (
  .clk(clk), .rst_n(rst_n), .info(info), .chk(chk),
  .f(f), .g(g), .error(error)
);

// File: tb/berger_tsc_checker_tb.sv
module berger_tsc_checker_tb;

  localparam int IW = 8;
  localparam int CW = $clog2(IW + 1);
  localparam int NW = IW + CW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [IW-1:0] c_info, r_info;
  logic [CW-1:0] c_chk, r_chk;
  logic c_f, c_g, c_err, r_f, r_g, r_err;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  berger_tsc_checker #(.INFO_W(IW), .REGISTERED(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .info(r_info), .chk(r_chk),
    .f(r_f), .g(r_g), .error(r_err));

  berger_tsc_checker #(.INFO_W(IW), .REGISTERED(1'b0)) u_dut_c (
    .clk(clk), .rst_n(rst_n), .info(c_info), .chk(c_chk),
    .f(c_f), .g(c_g), .error(c_err));

  function automatic int zeros(logic [IW-1:0] v);
    int z = 0;
    for (int b = 0; b < IW; b++) if (!v[b]) z++;
    return z;
  endfunction

  task automatic check(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_word(string req, logic [NW-1:0] cw);
    logic bad;
    c_info = cw[NW-1:CW];
    c_chk  = cw[CW-1:0];
    #1;
    bad = (zeros(c_info) != int'(c_chk));
    check(req, c_f == c_g, bad);
  endtask

  initial begin
    logic [NW-1:0] lfsr;
    logic [NW-1:0] cw;
    logic [IW-1:0] prev_i;
    logic [CW-1:0] prev_c;
    c_info = '0; c_chk = '0; r_info = '0; r_chk = '0;

    repeat (3) @(posedge clk);
    #1;
    check("R9 reset f", r_f, 1'b0);
    check("R9 reset g", r_g, 1'b1);
    check("R9 reset error", r_err, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    c_info = 8'b10101000; c_chk = 4'b0101; #1;
    check("R2 example pair", c_f != c_g, 1'b1);
    check("R2 example error", c_err, 1'b0);
    check("R1 width", 1'b1, ($bits(c_chk) == 4));

    for (int i = 0; i < (1 << IW); i++) begin
      for (int c = 0; c < (1 << CW); c++) begin
        c_info = IW'(i); c_chk = CW'(c); #1;
        if (zeros(IW'(i)) == c) begin
          check("R3 valid codeword", c_f != c_g, 1'b1);
          check("R7 error low", c_err, 1'b0);
        end else begin
          check("R4 non-codeword", c_f == c_g, 1'b1);
          check("R7 error high", c_err, 1'b1);
        end
      end
    end

    for (int i = 0; i < (1 << IW); i++) begin
      for (int b = 0; b < NW; b++) begin
        cw = {IW'(i), CW'(zeros(IW'(i)))};
        cw[b] = ~cw[b];
        check_word("R5 single flip", cw);
      end
    end

    lfsr = NW'(12'hACE);
    for (int i = 0; i < (1 << IW); i++) begin
      for (int k = 0; k < 6; k++) begin
        logic [NW-1:0] base;
        lfsr = {lfsr[NW-2:0], lfsr[NW-1] ^ lfsr[5] ^ lfsr[3] ^ lfsr[0]};
        base = {IW'(i), CW'(zeros(IW'(i)))};
        if ((base | lfsr) != base) check_word("R6 rising burst", base | lfsr);
        if ((base & ~lfsr) != base) check_word("R6 falling burst", base & ~lfsr);
      end
      if (~{IW'(i), CW'(zeros(IW'(i)))} != '0)
        check_word("R6 all ones", '1);
    end

    prev_i = r_info; prev_c = r_chk;
    for (int v = 0; v < 300; v++) begin
      @(negedge clk);
      lfsr = {lfsr[NW-2:0], lfsr[NW-1] ^ lfsr[5] ^ lfsr[3] ^ lfsr[0]};
      r_info = lfsr[NW-1:CW];
      r_chk  = (v % 2 == 0) ? CW'(zeros(lfsr[NW-1:CW])) : lfsr[CW-1:0];
      #3;
      check("R8 hold before edge", r_err, zeros(prev_i) != int'(prev_c));
      @(posedge clk); #1;
      check("R8 one cycle latency", r_err, zeros(r_info) != int'(r_chk));
      check("R8 rails", r_f == r_g, zeros(r_info) != int'(r_chk));
      prev_i = r_info; prev_c = r_chk;
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule